// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block reshapes a vector register under a one-bit-per-element mask. In compress mode it collects the source elements whose mask bit is set and packs them, lowest index first, into the bottom of the destination. It also returns how many elements were packed. In expand mode it does the reverse: source elements are taken from index 0 upward and placed, in order, into the destination slots whose mask bit is set.

Destination slots that the operation does not write keep the value of the prior destination vector supplied with the request. A vector-length input limits which mask bits count. One request is accepted per cycle through a start strobe. The result and count are registered, and a done strobe marks them valid on the following cycle.

Top module: `vcx_unit`

## Requirements
- R1: While reset is asserted and after its release, before any request, `done` is 0 and `result` and `count` are all zeros.
- R2: `done` is 1 exactly in the cycle after a cycle in which `start` was 1, and 0 in every other cycle.
- R3: With `op`=0 (compress), active source elements are written to destination indices 0, 1, 2, … in ascending source-index order. Element i occupies bits [i*W +: W] of every vector port.
- R4: With `op`=0, destination indices at or above the packed count take the matching element of `old_vec`.
- R5: For both opcodes, `count` equals the number of active elements.
- R6: With `op`=1 (expand), source element k is written to the destination index of the (k+1)-th active position, counting from index 0.
- R7: With `op`=1, destination indices whose element is not active take the matching element of `old_vec`.
- R8: Element i is active only when mask bit i is 1 and i < `vlen`. A `vlen` larger than N acts as N.
- R9: With no active element (mask zero or `vlen` 0), `count` is 0 and `result` equals `old_vec` for both opcodes.
- R10: `result` and `count` keep their values in every cycle that follows a cycle without `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one request per cycle |
| op | input | 1 | 0 = compress, 1 = expand |
| src_vec | input | N*W | Source vector |
| mask | input | N | Per-element mask |
| old_vec | input | N*W | Prior destination contents |
| vlen | input | $clog2(N+1) | Active vector length |
| result | output | N*W | Registered destination vector |
| count | output | $clog2(N+1) | Registered number of active elements |
| done | output | 1 | One-cycle valid strobe |

## Verification
The assertions assume that the operands are stable and sampled only in the cycle `start` is high, and that `vlen` is meaningful only in that cycle. The bench therefore changes operands only together with a start pulse, on the falling edge, and drops `start` for at least two cycles between requests so that hold behaviour can be seen at the ports. The stimulus includes the sparse mask from the worked example, full and empty masks, a zero length, a short length that cuts off set mask bits, and a length above N.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
   typedef enum logic {
      VCX_COMPRESS = 1'b0,
      VCX_EXPAND   = 1'b1
   } vcx_op_e;
endpackage

// File: rtl/vcx_prefix.sv
module vcx_prefix #(
   parameter int N  = 8,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]    act,
   output logic [N*CW-1:0] rank,
   output logic [CW-1:0]   total
);
   always_comb begin
      logic [CW-1:0] acc;
      acc  = '0;
      rank = '0;
      for (int i = 0; i < N; i++) begin
         rank[i*CW +: CW] = acc;
         acc = acc + CW'(act[i]);
      end
      total = acc;
   end
endmodule

// File: rtl/vcx_route.sv
module vcx_route
   import vcx_pkg::*;
#(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int CW = $clog2(N + 1)
) (
   input  vcx_op_e         op,
   input  logic [N*W-1:0]  src_vec,
   input  logic [N*W-1:0]  old_vec,
   input  logic [N-1:0]    act,
   input  logic [N*CW-1:0] rank,
   output logic [N*W-1:0]  nxt
);
   for (genvar j = 0; j < N; j++) begin : g_dst
      logic [W-1:0] packed_el;
      logic [W-1:0] spread_el;

      always_comb begin
         packed_el = old_vec[j*W +: W];
         for (int i = 0; i < N; i++) begin
            if (act[i] && rank[i*CW +: CW] == CW'(j))
               packed_el = src_vec[i*W +: W];
         end
      end

      always_comb begin
         spread_el = old_vec[j*W +: W];
         if (act[j]) begin
            for (int k = 0; k < N; k++) begin
               if (rank[j*CW +: CW] == CW'(k))
                  spread_el = src_vec[k*W +: W];
            end
         end
      end

      assign nxt[j*W +: W] = (op == VCX_EXPAND) ? spread_el : packed_el;
   end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
   import vcx_pkg::*;
#(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int CW = $clog2(N + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           op,
   input  logic [N*W-1:0] src_vec,
   input  logic [N-1:0]   mask,
   input  logic [N*W-1:0] old_vec,
   input  logic [CW-1:0]  vlen,
   output logic [N*W-1:0] result,
   output logic [CW-1:0]  count,
   output logic           done
);
   if (N < 2) begin : g_bad_n
      $error("vcx_unit: N must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("vcx_unit: W must be at least 1");
   end

   logic [N-1:0]    act;
   logic [N*CW-1:0] rank;
   logic [CW-1:0]   total;
   logic [N*W-1:0]  nxt;

   for (genvar i = 0; i < N; i++) begin : g_act
      assign act[i] = mask[i] && (vlen > CW'(i));
   end

   vcx_prefix #(.N(N), .CW(CW)) u_prefix (
      .act   (act),
      .rank  (rank),
      .total (total)
   );

   vcx_route #(.N(N), .W(W), .CW(CW)) u_route (
      .op      (vcx_op_e'(op)),
      .src_vec (src_vec),
      .old_vec (old_vec),
      .act     (act),
      .rank    (rank),
      .nxt     (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         count  <= '0;
         done   <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            result <= nxt;
            count  <= total;
         end
      end
   end
endmodule

// File: rtl/vcx_chk.sv
module vcx_chk #(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int CW = $clog2(N + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [N-1:0]   mask,
   input logic [N*W-1:0] old_vec,
   input logic [CW-1:0]  vlen,
   input logic [N*W-1:0] result,
   input logic [CW-1:0]  count,
   input logic           done
);
   // R2
   done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   // R5
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count <= $past(vlen)) && (count <= CW'(N)));
   // R5
   full_len_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && vlen >= CW'(N)) |=> count == CW'($countones($past(mask))));
   // R9
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mask == '0) |=> (count == '0) && (result == $past(old_vec)));
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result) && $stable(count));
endmodule

bind vcx_unit vcx_chk #(.N(N), .W(W), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mask    (mask),
   .old_vec (old_vec),
   .vlen    (vlen),
   .result  (result),
   .count   (count),
   .done    (done)
);

// File: tb/vcx_unit_test.sv
module vcx_unit_test;
   localparam int N  = 8;
   localparam int W  = 8;
   localparam int CW = $clog2(N + 1);

   typedef struct {
      logic [N*W-1:0] res;
      logic [CW-1:0]  cnt;
      string          tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           op = 1'b0;
   logic [N*W-1:0] src_vec = '0;
   logic [N-1:0]   mask = '0;
   logic [N*W-1:0] old_vec = '0;
   logic [CW-1:0]  vlen = '0;
   logic [N*W-1:0] result;
   logic [CW-1:0]  count;
   logic           done;

   int   total_n = 0;
   int   bad_n = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   finished = 0;
   exp_t sb[$];

   always #5 clk = ~clk;

   vcx_unit #(.N(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_vec(src_vec), .mask(mask), .old_vec(old_vec), .vlen(vlen),
      .result(result), .count(count), .done(done)
   );

   task automatic check(input bit ok, input string tag, input logic [N*W-1:0] act_v,
                        input logic [N*W-1:0] exp_v);
      total_n++;
      if (!ok) begin
         bad_n++;
         $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
      end
   endtask

   function automatic exp_t model(input logic o, input logic [N*W-1:0] s,
                                  input logic [N-1:0] m, input logic [N*W-1:0] d,
                                  input int len, input string tag);
      exp_t e;
      int   k = 0;
      e.res = d;
      for (int i = 0; i < N; i++) begin
         if (m[i] && i < len) begin
            if (o) e.res[i*W +: W] = s[k*W +: W];
            else   e.res[k*W +: W] = s[i*W +: W];
            k++;
         end
      end
      e.cnt = CW'(k);
      e.tag = tag;
      return e;
   endfunction

   task automatic run(input logic o, input logic [N-1:0] m, input int len, input string tag);
      exp_t e;
      logic [N*W-1:0] held;
      logic [CW-1:0]  held_c;
      e = model(o, src_vec, m, old_vec, len, tag);
      sb.push_back(e);
      pushed++;
      @(negedge clk);
      op = o; mask = m; vlen = CW'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      held = result; held_c = count;
      src_vec = ~src_vec; old_vec = old_vec ^ {N{8'h5A}}; mask = ~mask;
      @(negedge clk);
      check(done == 1'b0, {tag, " R2 done low after pulse"}, N*W'(done), '0);
      check(result == held && count == held_c, {tag, " R10 hold"}, result, held);
      src_vec = ~src_vec; old_vec = old_vec ^ {N{8'h5A}};
   endtask

   always @(negedge clk) begin
      if (rst_n && done && !finished) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected done", N*W'(done), '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            popped++;
            check(result == e.res, {e.tag, " result"}, result, e.res);
            check(count == e.cnt, {e.tag, " R5 count"}, N*W'(count), N*W'(e.cnt));
         end
      end
   end

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total_n, bad_n);
         $finish;
      end
   endtask

   initial begin
      #200000;
      check(1'b0, "watchdog expired", '0, '0);
      finish_up();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         src_vec[i*W +: W] = W'(8'hA0 + i);
         old_vec[i*W +: W] = W'(8'hC0 + i);
      end
      repeat (3) @(negedge clk);
      check(done == 0 && result == '0 && count == '0, "R1 reset state", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 0 && result == '0 && count == '0, "R1 after release", result, '0);

      run(1'b0, 8'hB2, 8,  "R3 R4 compress sparse");
      run(1'b1, 8'hB2, 8,  "R6 R7 expand sparse");
      run(1'b0, 8'hFF, 8,  "R3 compress full");
      run(1'b1, 8'hFF, 8,  "R6 expand full");
      run(1'b1, 8'hFF, 5,  "R8 expand short length");
      run(1'b0, 8'hF0, 6,  "R8 compress short length");
      run(1'b0, 8'h81, 12, "R8 compress length above N");
      run(1'b0, 8'h00, 8,  "R9 compress empty mask");
      run(1'b1, 8'h00, 8,  "R9 expand empty mask");
      run(1'b1, 8'hFF, 0,  "R9 expand zero length");
      run(1'b1, 8'h5A, 7,  "R6 R7 expand alternating");

      repeat (2) @(negedge clk);
      check(pushed == popped, "R2 one done per start", N*W'(popped), N*W'(pushed));
      finish_up();
   end
endmodule